// File: doc/BRIEF.md
# Sampling Speed Frequency Stabilizer

This block holds the speed of a free-running sampling wave at a programmed rate. It counts the turn pulses of the wave over a measurement gate of a programmable number of reference-clock cycles. At the end of each gate it compares the count with a target and corrects a 16-bit word that an external DAC turns into the speed control voltage. The loop is meant to cancel slow drift, such as the wave slowing down as the chip warms up. It is not meant to follow turn-to-turn jitter.

The word must stay fixed while the sampler is recording. An acquisition-busy input therefore freezes the output. Corrections that fall due during an acquisition are accumulated in a pending word. That word is released on the first clock edge after busy drops. Every change of the word comes with a one-cycle load strobe for the DAC. The last measured count is reported. A lock flag reports whether a run of consecutive gates has stayed within a tolerance.

Top module: `speed_stabilizer`

## Requirements
- R1: While `rst_n` is low, and after its release until the first update, `dac_word` is 32768 (mid-scale), and `dac_load`, `meas_count` and `locked` are 0.
- R2: A gate spans max(`gate_len`,1) clock cycles. On its last cycle `meas_count` takes the number of rising edges of the wave detected during that gate, and counting restarts from zero for the next gate. With one rising edge every 2 cycles and `gate_len`=64, the count is 32.
- R3: One cycle after a gate ends, the error e = `target` − count is computed. If busy is low, `dac_word` becomes the previous word plus (e arithmetically shifted right by `gain_shift`, rounding toward minus infinity), and `dac_load` is high for that one cycle. `dac_word` never changes without `dac_load`.
- R4: The updated word saturates: a sum below 0 gives 0, and a sum above 65535 gives 65535.
- R5: On the cycle after any cycle sampled with `busy` high, `dac_word` is unchanged and `dac_load` is low.
- R6: A correction that falls due while `busy` is high goes into a pending word. A further correction during the same acquisition builds on that pending word. On the first clock edge at which `busy` is sampled low, the pending word is moved to `dac_word` with a one-cycle `dac_load`.
- R7: `locked` rises when N = `lock_need` consecutive gates each have |e| ≤ `tolerance`. N=0 behaves as one gate.
- R8: Any gate with |e| > `tolerance` clears `locked` and restarts the run count.
- R9: `wave_in` passes through a two-flop synchronizer and edge detector. Each low-to-high transition is counted once, and a level held high adds no further counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all gating and state run on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wave_in | input | 1 | Turn pulses of the sampling wave, asynchronous |
| busy | input | 1 | Acquisition in progress; freezes the control word |
| gate_len | input | 16 | Gate length in clock cycles |
| target | input | 16 | Wanted pulse count per gate |
| gain_shift | input | 4 | Right-shift applied to the error |
| tolerance | input | 16 | Largest absolute error still counted as in lock |
| lock_need | input | 4 | Number of consecutive in-tolerance gates needed for lock |
| dac_word | output | 16 | Speed control word for the DAC |
| dac_load | output | 1 | One-cycle strobe on each change of `dac_word` |
| meas_count | output | 16 | Pulse count of the last completed gate |
| locked | output | 1 | Lock indication |

## Verification
Each result has a fixed delay. A wave edge is counted on the third rising clock edge after it arrives. `meas_count` moves on the final edge of its gate. `dac_word`, `dac_load` and `locked` follow one edge later. A pending word moves on the first edge that samples `busy` low. The bench drives inputs on falling edges. It steps a behavioural model on each rising edge, which applies exactly these delays, and compares all four outputs on the following falling edge. Directed checks sit at cycle counts worked out from the same delays. Where a gate boundary may line up with a busy edge, the directed check accepts only the two outcomes that these delays allow.

// File: rtl/ss_pkg.sv
// Shared defaults and the control-update action type of the speed stabilizer.
package ss_pkg;
    localparam int DEF_DAC_W   = 16;
    localparam int DEF_CNT_W   = 16;
    localparam int DEF_GATE_W  = 16;
    localparam int DEF_SHIFT_W = 4;
    localparam int DEF_LOCK_W  = 4;

    typedef enum logic [1:0] {
        ACT_NONE,   // nothing to do this cycle
        ACT_HOLD,   // correction computed during acquisition: park it
        ACT_APPLY,  // correction computed while idle: drive it out
        ACT_FLUSH   // acquisition over: release the parked word
    } ctrl_act_e;
endpackage

// File: rtl/ss_pulse_sync.sv
// Brings the asynchronous wave pulse into the clock domain and flags rising edges.
// Assumes pulses stay high and low for at least one clock period each.
module ss_pulse_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wave_in,
    output logic rise
);
    logic [SYNC_STAGES:0] pipe;

    // Synchronizer chain plus one extra stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[SYNC_STAGES-1:0], wave_in};
    end

    // A rising edge is a new high behind an old low
    assign rise = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
endmodule

// File: rtl/ss_gate_counter.sv
// Counts edge flags over a gate of gate_len clocks and latches the total at its end.
// Assumes gate_len of zero means a one-cycle gate; the count saturates.
module ss_gate_counter #(
    parameter int CNT_W  = ss_pkg::DEF_CNT_W,
    parameter int GATE_W = ss_pkg::DEF_GATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic [GATE_W-1:0] gate_len,
    output logic [CNT_W-1:0]  meas_count,
    output logic              meas_valid
);
    logic [GATE_W-1:0] gate_pos;
    logic [CNT_W-1:0]  acc;
    logic [CNT_W-1:0]  acc_inc;
    logic              gate_end;

    // Gate closes on the cycle whose position is the last one
    assign gate_end = ({1'b0, gate_pos} + (GATE_W+1)'(1)) >= {1'b0, gate_len};
    // Add the current edge, holding at full scale
    assign acc_inc  = (rise && acc != '1) ? acc + CNT_W'(1) : acc;

    // Advance the gate, accumulate, and latch at the gate boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_pos   <= '0;
            acc        <= '0;
            meas_count <= '0;
            meas_valid <= 1'b0;
        end else if (gate_end) begin
            gate_pos   <= '0;
            acc        <= '0;
            meas_count <= acc_inc;
            meas_valid <= 1'b1;
        end else begin
            gate_pos   <= gate_pos + GATE_W'(1);
            acc        <= acc_inc;
            meas_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ss_ctrl_update.sv
// Turns each new count into a saturated correction of the DAC word, parking it
// while busy is high and releasing it on the first idle edge.
// Assumes meas_valid is a single-cycle pulse per gate.
module ss_ctrl_update #(
    parameter int          DAC_W    = ss_pkg::DEF_DAC_W,
    parameter int          CNT_W    = ss_pkg::DEF_CNT_W,
    parameter int          SHIFT_W  = ss_pkg::DEF_SHIFT_W,
    parameter int unsigned DAC_INIT = 32768
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               meas_valid,
    input  logic [CNT_W-1:0]   meas_count,
    input  logic [CNT_W-1:0]   target,
    input  logic [SHIFT_W-1:0] gain_shift,
    input  logic               busy,
    output logic [DAC_W-1:0]   dac_word,
    output logic               dac_load,
    output logic               pend_valid
);
    import ss_pkg::*;

    localparam int ERR_W = CNT_W + 1;
    localparam int MAX_W = (CNT_W > DAC_W) ? CNT_W : DAC_W;
    localparam int SUM_W = MAX_W + 2;

    logic [DAC_W-1:0]        pend_word;
    logic [DAC_W-1:0]        base;
    logic [DAC_W-1:0]        next_word;
    logic signed [ERR_W-1:0] err;
    logic signed [ERR_W-1:0] delta;
    logic signed [SUM_W-1:0] delta_ext;
    logic signed [SUM_W-1:0] base_ext;
    logic signed [SUM_W-1:0] sum;
    ctrl_act_e               act;

    // Signed error and its scaled step
    assign err       = $signed({1'b0, target}) - $signed({1'b0, meas_count});
    assign delta     = err >>> gain_shift;
    // Corrections stack on the parked word if one is waiting
    assign base      = pend_valid ? pend_word : dac_word;
    assign delta_ext = {{(SUM_W-ERR_W){delta[ERR_W-1]}}, delta};
    assign base_ext  = $signed({{(SUM_W-DAC_W){1'b0}}, base});
    assign sum       = base_ext + delta_ext;

    // Clamp the sum into the DAC range
    always_comb begin
        if (sum[SUM_W-1])                 next_word = '0;
        else if (|sum[SUM_W-2:DAC_W])     next_word = '1;
        else                              next_word = sum[DAC_W-1:0];
    end

    // Choose what happens to the word this cycle
    always_comb begin
        if (meas_valid)                act = busy ? ACT_HOLD : ACT_APPLY;
        else if (pend_valid && !busy)  act = ACT_FLUSH;
        else                           act = ACT_NONE;
    end

    // Word, parked word and strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_word   <= DAC_W'(DAC_INIT);
            pend_word  <= DAC_W'(DAC_INIT);
            pend_valid <= 1'b0;
            dac_load   <= 1'b0;
        end else begin
            dac_load <= 1'b0;
            case (act)
                ACT_HOLD: begin
                    pend_word  <= next_word;
                    pend_valid <= 1'b1;
                end
                ACT_APPLY: begin
                    dac_word   <= next_word;
                    dac_load   <= 1'b1;
                    pend_valid <= 1'b0;
                end
                ACT_FLUSH: begin
                    dac_word   <= pend_word;
                    dac_load   <= 1'b1;
                    pend_valid <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ss_lock_detect.sv
// Tracks a run of in-tolerance gates and raises the lock flag once the run is long enough.
// Assumes meas_valid is a single-cycle pulse per gate.
module ss_lock_detect #(
    parameter int CNT_W  = ss_pkg::DEF_CNT_W,
    parameter int LOCK_W = ss_pkg::DEF_LOCK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_valid,
    input  logic [CNT_W-1:0]  meas_count,
    input  logic [CNT_W-1:0]  target,
    input  logic [CNT_W-1:0]  tolerance,
    input  logic [LOCK_W-1:0] lock_need,
    output logic              locked
);
    logic [CNT_W-1:0]  abs_err;
    logic [LOCK_W-1:0] streak;
    logic [LOCK_W-1:0] streak_next;
    logic              in_tol;

    // Magnitude of the error without a sign bit
    assign abs_err     = (target >= meas_count) ? target - meas_count : meas_count - target;
    assign in_tol      = abs_err <= tolerance;
    // Run length stops growing once it meets the requirement
    assign streak_next = (streak >= lock_need) ? streak : streak + LOCK_W'(1);

    // Update run length and flag once per gate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            streak <= '0;
            locked <= 1'b0;
        end else if (meas_valid) begin
            if (in_tol) begin
                streak <= streak_next;
                locked <= streak_next >= lock_need;
            end else begin
                streak <= '0;
                locked <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/speed_stabilizer.sv
// Frequency stabilizer for a free-running sampling wave: measures turn pulses per
// gate and steers a DAC word, changing it only while no acquisition is running.
// Assumes clk is the reference clock and wave_in is asynchronous to it.
module speed_stabilizer #(
    parameter int          DAC_W       = ss_pkg::DEF_DAC_W,
    parameter int          CNT_W       = ss_pkg::DEF_CNT_W,
    parameter int          GATE_W      = ss_pkg::DEF_GATE_W,
    parameter int          SHIFT_W     = ss_pkg::DEF_SHIFT_W,
    parameter int          LOCK_W      = ss_pkg::DEF_LOCK_W,
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned DAC_INIT    = 32768
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wave_in,
    input  logic               busy,
    input  logic [GATE_W-1:0]  gate_len,
    input  logic [CNT_W-1:0]   target,
    input  logic [SHIFT_W-1:0] gain_shift,
    input  logic [CNT_W-1:0]   tolerance,
    input  logic [LOCK_W-1:0]  lock_need,
    output logic [DAC_W-1:0]   dac_word,
    output logic               dac_load,
    output logic [CNT_W-1:0]   meas_count,
    output logic               locked
);
    logic rise;
    logic meas_valid;
    logic pend_valid;

    ss_pulse_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .wave_in(wave_in), .rise(rise)
    );

    ss_gate_counter #(.CNT_W(CNT_W), .GATE_W(GATE_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .rise(rise), .gate_len(gate_len),
        .meas_count(meas_count), .meas_valid(meas_valid)
    );

    ss_ctrl_update #(.DAC_W(DAC_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .DAC_INIT(DAC_INIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_count(meas_count),
        .target(target), .gain_shift(gain_shift), .busy(busy),
        .dac_word(dac_word), .dac_load(dac_load), .pend_valid(pend_valid)
    );

    ss_lock_detect #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_count(meas_count),
        .target(target), .tolerance(tolerance), .lock_need(lock_need), .locked(locked)
    );
endmodule

// File: rtl/ss_checker.sv
// Temporal checks on the stabilizer outputs, bound into every instance of the top.
module ss_checker #(
    parameter int DAC_W = ss_pkg::DEF_DAC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [DAC_W-1:0] dac_word,
    input logic             dac_load,
    input logic             locked,
    input logic             meas_valid,
    input logic             pend_valid
);
    AST_WORD_MOVES_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_word) |-> dac_load);                                          // R3
    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dac_word));                                               // R5
    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dac_load);                                                       // R5
    AST_PENDING_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pend_valid) |=> (dac_load && !pend_valid));                      // R6
    AST_LOCK_ON_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(meas_valid));                                      // R7
    AST_UNLOCK_ON_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(meas_valid));                                      // R8
endmodule

bind speed_stabilizer ss_checker #(.DAC_W(DAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dac_word(dac_word), .dac_load(dac_load),
    .locked(locked), .meas_valid(meas_valid), .pend_valid(pend_valid)
);

// File: tb/tb_speed_stabilizer.sv
// Self-checking bench: behavioural model stepped on every rising edge, outputs
// compared on every falling edge, plus directed checks per requirement.
module tb_speed_stabilizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wave_in = 1'b0;
    logic        busy = 1'b0;
    logic [15:0] gate_len = 16'd64;
    logic [15:0] target = 16'd32;
    logic [3:0]  gain_shift = 4'd0;
    logic [15:0] tolerance = 16'd1;
    logic [3:0]  lock_need = 4'd3;
    logic [15:0] dac_word;
    logic        dac_load;
    logic [15:0] meas_count;
    logic        locked;

    int errors = 0;
    int checks = 0;
    int wave_period = 2;   // 0: hold wave_level
    logic wave_level = 1'b0;
    int wave_ph = 0;
    bit done = 0;

    speed_stabilizer dut (
        .clk(clk), .rst_n(rst_n), .wave_in(wave_in), .busy(busy),
        .gate_len(gate_len), .target(target), .gain_shift(gain_shift),
        .tolerance(tolerance), .lock_need(lock_need),
        .dac_word(dac_word), .dac_load(dac_load), .meas_count(meas_count), .locked(locked)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Wave pulse generator: one-cycle high every wave_period cycles
    always @(negedge clk) begin
        if (wave_period == 0) begin
            wave_in <= wave_level;
        end else begin
            wave_in <= (wave_ph == 0);
            wave_ph = (wave_ph + 1) % wave_period;
        end
    end

    // Behavioural reference model
    int m_hist[$] = '{0, 0, 0};
    int m_gpos = 0, m_acc = 0, m_meas = 0, m_mv = 0;
    int m_dac = 32768, m_load = 0, m_pv = 0, m_pw = 32768;
    int m_streak = 0, m_locked = 0;

    always @(posedge clk) begin
        int rise, err, step, nw, base, ae, glen, tot;
        if (!rst_n) begin
            m_hist = '{0, 0, 0};
            m_gpos = 0; m_acc = 0; m_meas = 0; m_mv = 0;
            m_dac = 32768; m_load = 0; m_pv = 0; m_pw = 32768;
            m_streak = 0; m_locked = 0;
        end else begin
            rise = (m_hist[1] == 1 && m_hist[2] == 0) ? 1 : 0;
            m_load = 0;
            if (m_mv == 1) begin
                err  = int'(target) - m_meas;
                step = err >>> gain_shift;
                base = m_pv ? m_pw : m_dac;
                nw   = base + step;
                if (nw < 0) nw = 0;
                if (nw > 65535) nw = 65535;
                if (busy) begin m_pw = nw; m_pv = 1; end
                else begin m_dac = nw; m_load = 1; m_pv = 0; end
                ae = (err < 0) ? -err : err;
                if (ae <= int'(tolerance)) begin
                    if (m_streak < int'(lock_need)) m_streak++;
                    m_locked = (m_streak >= int'(lock_need)) ? 1 : 0;
                end else begin
                    m_streak = 0; m_locked = 0;
                end
            end else if (m_pv == 1 && !busy) begin
                m_dac = m_pw; m_pv = 0; m_load = 1;
            end
            glen = (gate_len == 0) ? 1 : int'(gate_len);
            tot  = m_acc + rise;
            if (tot > 65535) tot = 65535;
            if (m_gpos + 1 >= glen) begin
                m_meas = tot; m_acc = 0; m_gpos = 0; m_mv = 1;
            end else begin
                m_acc = tot; m_gpos++; m_mv = 0;
            end
            m_hist.push_front(int'(wave_in));
            void'(m_hist.pop_back());
        end
    end

    // Cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (!done) begin
            chk("R2 meas_count", int'(meas_count), m_meas);
            chk("R3 dac_word", int'(dac_word), m_dac);
            chk("R6 dac_load", int'(dac_load), m_load);
            chk("R7 locked", int'(locked), m_locked);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_load();
        @(negedge clk);
        while (!dac_load) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(190000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int rec, d1, d2, diff;
        cycles(3);
        // R1: reset values
        chk("R1 dac_word", int'(dac_word), 32768);
        chk("R1 dac_load", int'(dac_load), 0);
        chk("R1 meas_count", int'(meas_count), 0);
        chk("R1 locked", int'(locked), 0);
        rst_n = 1'b1;
        cycles(1);
        chk("R1 dac_word after release", int'(dac_word), 32768);

        // R7: not locked after two gates, locked after three (release edge counted as 1)
        cycles(132);
        chk("R7 locked after 2 gates", int'(locked), 0);
        cycles(64);
        chk("R7 locked after 3 gates", int'(locked), 1);
        cycles(200);
        // R2: one edge every 2 cycles over 64 cycles gives 32
        chk("R2 steady count", int'(meas_count), 32);

        // R3, R8: slower wave, gain shift 2: +4 per gate, lock drops
        wave_period = 4;
        gain_shift = 4'd2;
        wait_load(); wait_load();
        wait_load(); d1 = int'(dac_word);
        wait_load(); d2 = int'(dac_word);
        chk("R3 step of (32-16)>>2", d2 - d1, 4);
        chk("R8 lock cleared", int'(locked), 0);
        chk("R9 count at period 4", int'(meas_count), 16);

        // R5, R6: freeze during acquisition, release afterwards
        busy = 1'b1;
        cycles(1);
        rec = int'(dac_word);
        for (int i = 0; i < 200; i++) begin
            cycles(1);
            if (i == 100) begin
                chk("R5 word frozen", int'(dac_word), rec);
                chk("R5 no strobe", int'(dac_load), 0);
            end
        end
        busy = 1'b0;
        cycles(1);
        chk("R6 strobe on release", int'(dac_load), 1);
        diff = int'(dac_word) - rec;
        chk("R6 pending accumulated", (diff == 12 || diff == 16) ? 1 : 0, 1);

        // R9: level held high contributes no edges
        wave_period = 0;
        wave_level = 1'b1;
        cycles(200);
        chk("R9 held level counts 0", int'(meas_count), 0);
        wave_level = 1'b0;

        // R7 with tolerance: exact target at lock_need 0
        wave_period = 2;
        lock_need = 4'd0;
        tolerance = 16'd0;
        cycles(200);
        chk("R7 lock with need 0", int'(locked), 1);

        // R4: saturation at zero
        gain_shift = 4'd0;
        target = 16'd0;
        gate_len = 16'd20000;
        for (int i = 0; i < 6; i++) begin
            wait_load();
            if (dac_word == 16'd0) break;
        end
        chk("R4 floor reached", int'(dac_word), 0);
        chk("R8 out of tolerance", int'(locked), 0);
        wait_load();
        chk("R4 floor held", int'(dac_word), 0);

        // R4: saturation at full scale
        gate_len = 16'd64;
        target = 16'd65535;
        wait_load(); wait_load();
        chk("R4 ceiling", int'(dac_word), 65535);
        wait_load();
        chk("R4 ceiling held", int'(dac_word), 65535);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule